// File: doc/BRIEF.md
# Next Program Counter Selector

This block forms the next word address of the program counter in a core that completes one instruction per clock. It works in word units: the two low address bits are always zero and are neither taken in nor given out. From the current word address it produces the incremented address, which also serves as the link value written by jump-and-link. It then picks one of four sources for the next address: the sequential path, the jump-target path, the register path, or a fixed trap entry.

The sequential path chooses between the incremented address and a PC-relative branch target. The choice comes from a 2-bit branch kind and two condition inputs: the equality flag from the ALU and the sign bit of the register operand. The decoder drives the source select and the branch kind. The PC register samples `next_pc_o` on its own clock edge. The block holds no state.

Top module: `nextpc_unit`

## Requirements
- R1: `pc_inc_o` equals `pc_i + 1` modulo 2^30, wrapping from all ones to zero, whatever the other inputs are.
- R2: With `pc_src_i` = 00 and `br_kind_i` = 00 (no branch), `next_pc_o` equals `pc_i + 1` for any value of `eq_i` and of `rs_i[31]`.
- R3: With `pc_src_i` = 00 and `br_kind_i` = 01 (branch on equal), `next_pc_o` is the branch target when `eq_i` = 1 and `pc_i + 1` when `eq_i` = 0.
- R4: With `pc_src_i` = 00 and `br_kind_i` = 10 (branch on not equal), `next_pc_o` is the branch target when `eq_i` = 0 and `pc_i + 1` when `eq_i` = 1.
- R5: With `pc_src_i` = 00 and `br_kind_i` = 11 (branch if negative), `next_pc_o` is the branch target when `rs_i[31]` = 1 and `pc_i + 1` when it is 0. `eq_i` has no effect on this choice.
- R6: The branch target is `pc_i + 1 + sext(br_off_i)` modulo 2^30, where bit 15 of the 16-bit offset is copied into all higher bits.
- R7: With `pc_src_i` = 01, `next_pc_o` equals `{pc_i[29:26], jtarget_i[25:0]}`.
- R8: With `pc_src_i` = 10, `next_pc_o` equals `rs_i[31:2]`.
- R9: With `pc_src_i` = 11, `next_pc_o` equals the parameter `TRAP_ADDR`, whose default is 30'h0010_0000.
- R10: When `pc_src_i` is not 00, `br_kind_i`, `eq_i` and `br_off_i` have no effect on `next_pc_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 30 | Current word address (byte address bits 31:2) |
| br_off_i | input | 16 | Signed branch offset in words |
| jtarget_i | input | 26 | Jump target field |
| rs_i | input | 32 | Register operand; bits 31:2 are the register target and bit 31 is the sign |
| eq_i | input | 1 | ALU equality (zero) flag |
| br_kind_i | input | 2 | Branch kind: 00 none, 01 equal, 10 not equal, 11 negative |
| pc_src_i | input | 2 | Source select: 00 sequential or branch, 01 jump, 10 register, 11 trap |
| next_pc_o | output | 30 | Next word address |
| pc_inc_o | output | 30 | Incremented word address, also used as the link value |

## Verification
A branch condition can be true in the same cycle that the decoder selects the jump, register or trap source. The correct outcome is that the selected source wins and the branch is dropped. The bench provokes this by sweeping every combination of source select, branch kind, equality flag and operand sign. In each combination it places a distinct value on each source. It judges `next_pc_o` against a reference computed inside the bench. Separate cases cover wraparound of the increment and the branch target at the top and bottom of the address space.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQ   = 2'b01,
    BR_NE   = 2'b10,
    BR_LTZ  = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    SRC_SEQ  = 2'b00,
    SRC_JUMP = 2'b01,
    SRC_REG  = 2'b10,
    SRC_TRAP = 2'b11
  } pc_src_e;
endpackage

// File: rtl/nextpc_cond.sv
module nextpc_cond
  import nextpc_pkg::*;
(
  input  logic [1:0] br_kind_i,
  input  logic       eq_i,
  input  logic       neg_i,
  output logic       take_o
);
  br_kind_e kind;
  assign kind = br_kind_e'(br_kind_i);

  always_comb begin
    unique case (kind)
      BR_EQ:   take_o = eq_i;
      BR_NE:   take_o = ~eq_i;
      BR_LTZ:  take_o = neg_i;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nextpc_seq.sv
module nextpc_seq #(
  parameter int PC_W  = 30,
  parameter int IMM_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [IMM_W-1:0] off_i,
  input  logic             take_i,
  output logic [PC_W-1:0]  inc_o,
  output logic [PC_W-1:0]  seq_o
);
  localparam int EXT_W = PC_W - IMM_W;

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] tgt;

  assign off_ext = {{EXT_W{off_i[IMM_W-1]}}, off_i};
  assign inc_o   = pc_i + PC_W'(1);
  assign tgt     = inc_o + off_ext;
  assign seq_o   = take_i ? tgt : inc_o;
endmodule

// File: rtl/nextpc_sel.sv
module nextpc_sel #(
  parameter int PC_W  = 30,
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0][PC_W-1:0] cand_i,
  input  logic [SEL_W-1:0]           sel_i,
  output logic [PC_W-1:0]            next_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_dec
    assign hit[g] = (sel_i == SEL_W'(g));
  end

  // one-hot AND-OR mux
  always_comb begin
    next_o = '0;
    for (int k = 0; k < N_SRC; k++) begin
      next_o |= cand_i[k] & {PC_W{hit[k]}};
    end
  end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int              PC_W      = 30,
  parameter int              IMM_W     = 16,
  parameter int              JTA_W     = 26,
  parameter int              DATA_W    = 32,
  parameter logic [PC_W-1:0] TRAP_ADDR = 30'h0010_0000
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [IMM_W-1:0]  br_off_i,
  input  logic [JTA_W-1:0]  jtarget_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic              eq_i,
  input  logic [1:0]        br_kind_i,
  input  logic [1:0]        pc_src_i,
  output logic [PC_W-1:0]   next_pc_o,
  output logic [PC_W-1:0]   pc_inc_o
);
  localparam int SEG_W = PC_W - JTA_W;
  localparam int N_SRC = 4;

  logic                        take;
  logic [PC_W-1:0]             seq_pc;
  logic [PC_W-1:0]             jump_pc;
  logic [PC_W-1:0]             reg_pc;
  logic [N_SRC-1:0][PC_W-1:0]  cand;

  nextpc_cond u_cond (
    .br_kind_i (br_kind_i),
    .eq_i      (eq_i),
    .neg_i     (rs_i[DATA_W-1]),
    .take_o    (take)
  );

  nextpc_seq #(.PC_W(PC_W), .IMM_W(IMM_W)) u_seq (
    .pc_i   (pc_i),
    .off_i  (br_off_i),
    .take_i (take),
    .inc_o  (pc_inc_o),
    .seq_o  (seq_pc)
  );

  assign jump_pc = {pc_i[PC_W-1 -: SEG_W], jtarget_i};
  assign reg_pc  = rs_i[DATA_W-1 -: PC_W];

  assign cand[SRC_SEQ]  = seq_pc;
  assign cand[SRC_JUMP] = jump_pc;
  assign cand[SRC_REG]  = reg_pc;
  assign cand[SRC_TRAP] = TRAP_ADDR;

  nextpc_sel #(.PC_W(PC_W), .N_SRC(N_SRC)) u_sel (
    .cand_i (cand),
    .sel_i  (pc_src_i),
    .next_o (next_pc_o)
  );
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
  parameter int              PC_W      = 30,
  parameter int              IMM_W     = 16,
  parameter int              JTA_W     = 26,
  parameter int              DATA_W    = 32,
  parameter logic [PC_W-1:0] TRAP_ADDR = 30'h0010_0000
) (
  input logic [PC_W-1:0]   pc_i,
  input logic [IMM_W-1:0]  br_off_i,
  input logic [JTA_W-1:0]  jtarget_i,
  input logic [DATA_W-1:0] rs_i,
  input logic              eq_i,
  input logic [1:0]        br_kind_i,
  input logic [1:0]        pc_src_i,
  input logic [PC_W-1:0]   next_pc_o,
  input logic [PC_W-1:0]   pc_inc_o
);
  always_comb begin
    a_r1_inc_wraps: assert (pc_inc_o == PC_W'(pc_i + PC_W'(1)));
    if (pc_src_i == 2'b00 && br_kind_i == 2'b00)
      a_r2_no_branch: assert (next_pc_o == pc_inc_o);
    if (pc_src_i == 2'b00 && br_kind_i == 2'b01 && !eq_i)
      a_r3_eq_not_taken: assert (next_pc_o == pc_inc_o);
    if (pc_src_i == 2'b00 && br_kind_i == 2'b10 && eq_i)
      a_r4_ne_not_taken: assert (next_pc_o == pc_inc_o);
    if (pc_src_i == 2'b00 && br_kind_i == 2'b11 && !rs_i[DATA_W-1])
      a_r5_ltz_not_taken: assert (next_pc_o == pc_inc_o);
    if (pc_src_i == 2'b01)
      a_r7_jump: assert (next_pc_o[JTA_W-1:0] == jtarget_i &&
                         next_pc_o[PC_W-1:JTA_W] == pc_i[PC_W-1:JTA_W]);
    if (pc_src_i == 2'b10)
      a_r8_reg: assert (next_pc_o == rs_i[DATA_W-1:DATA_W-PC_W]);
    if (pc_src_i == 2'b11)
      a_r9_trap: assert (next_pc_o == TRAP_ADDR);
  end
endmodule

bind nextpc_unit nextpc_unit_chk #(
  .PC_W(PC_W), .IMM_W(IMM_W), .JTA_W(JTA_W), .DATA_W(DATA_W), .TRAP_ADDR(TRAP_ADDR)
) u_chk (
  .pc_i(pc_i), .br_off_i(br_off_i), .jtarget_i(jtarget_i), .rs_i(rs_i),
  .eq_i(eq_i), .br_kind_i(br_kind_i), .pc_src_i(pc_src_i),
  .next_pc_o(next_pc_o), .pc_inc_o(pc_inc_o)
);

// File: tb/nextpc_unit_tb.sv
module nextpc_unit_tb;
  localparam logic [29:0] TRAP = 30'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [29:0] pc_i = '0;
  logic [15:0] br_off_i = '0;
  logic [25:0] jtarget_i = '0;
  logic [31:0] rs_i = '0;
  logic        eq_i = 1'b0;
  logic [1:0]  br_kind_i = '0;
  logic [1:0]  pc_src_i = '0;
  logic [29:0] next_pc_o, pc_inc_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  nextpc_unit u_dut (
    .pc_i(pc_i), .br_off_i(br_off_i), .jtarget_i(jtarget_i), .rs_i(rs_i),
    .eq_i(eq_i), .br_kind_i(br_kind_i), .pc_src_i(pc_src_i),
    .next_pc_o(next_pc_o), .pc_inc_o(pc_inc_o)
  );

  task automatic check(input string req, input logic [29:0] act, input logic [29:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model written from the requirement text
  function automatic logic [29:0] model(input logic [1:0] src, input logic [1:0] kind,
                                        input logic eq, input logic [31:0] rs,
                                        input logic [29:0] pc, input logic [15:0] off,
                                        input logic [25:0] jt);
    logic [31:0] inc32, tgt32;
    logic        tk;
    inc32 = {2'b00, pc} + 32'd1;
    tgt32 = inc32 + {{16{off[15]}}, off};
    case (kind)
      2'b01:   tk = eq;
      2'b10:   tk = !eq;
      2'b11:   tk = rs[31];
      default: tk = 1'b0;
    endcase
    case (src)
      2'b00:   return tk ? tgt32[29:0] : inc32[29:0];
      2'b01:   return {pc[29:26], jt};
      2'b10:   return rs[31:2];
      default: return TRAP;
    endcase
  endfunction

  task automatic drive(input logic [1:0] src, input logic [1:0] kind, input logic eq,
                       input logic [31:0] rs, input logic [29:0] pc,
                       input logic [15:0] off, input logic [25:0] jt);
    @(posedge clk);
    pc_src_i = src; br_kind_i = kind; eq_i = eq; rs_i = rs;
    pc_i = pc; br_off_i = off; jtarget_i = jt;
    @(negedge clk);
  endtask

  function automatic string tag(input logic [1:0] src, input logic [1:0] kind);
    if (src != 2'b00) return "R10";
    case (kind)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic t_idle;
    drive(2'b00, 2'b00, 1'b0, '0, '0, '0, '0);
    check("R1 idle inc", pc_inc_o, 30'd1);
    check("R2 idle next", next_pc_o, 30'd1);
  endtask

  task automatic t_increment;
    drive(2'b00, 2'b00, 1'b1, 32'h8000_0000, 30'h3FFF_FFFF, 16'h7FFF, 26'h3FF_FFFF);
    check("R1 wrap", pc_inc_o, 30'd0);
    check("R2 wrap", next_pc_o, 30'd0);
    drive(2'b11, 2'b01, 1'b1, 32'h1234_5678, 30'h0ABC_DEF0, 16'h0004, 26'h0);
    check("R1 under trap", pc_inc_o, 30'h0ABC_DEF1);
  endtask

  task automatic t_offsets;
    drive(2'b00, 2'b01, 1'b1, '0, 30'h0000_1000, 16'hFFFF, '0);
    check("R6 minus one", next_pc_o, 30'h0000_1000);
    drive(2'b00, 2'b01, 1'b1, '0, 30'h0000_1000, 16'h8000, '0);
    check("R6 most negative", next_pc_o, 30'h3FFF_9001);
    drive(2'b00, 2'b10, 1'b0, '0, 30'h3FFF_FFF0, 16'h0020, '0);
    check("R6 wrap up", next_pc_o, 30'h0000_0011);
    drive(2'b00, 2'b11, 1'b0, 32'hFFFF_FFFC, 30'h0000_0002, 16'hFFF0, '0);
    check("R6 wrap down", next_pc_o, 30'h3FFF_FFF3);
  endtask

  task automatic t_jump;
    drive(2'b01, 2'b00, 1'b0, '0, 30'h2ABC_DEF0, '0, 26'h155_5555);
    check("R7 jump", next_pc_o, 30'h2955_5555);
    drive(2'b01, 2'b00, 1'b0, '0, 30'h3FFF_FFFF, '0, 26'h0);
    check("R7 jump top seg", next_pc_o, 30'h3C00_0000);
  endtask

  task automatic t_register;
    drive(2'b10, 2'b00, 1'b0, 32'hDEAD_BEEF, 30'h1, '0, '0);
    check("R8 reg", next_pc_o, 30'h37AB_6FBB);
  endtask

  task automatic t_trap;
    drive(2'b11, 2'b00, 1'b0, 32'hFFFF_FFFF, 30'h3FFF_FFFF, 16'hFFFF, 26'h3FF_FFFF);
    check("R9 trap", next_pc_o, TRAP);
  endtask

  // every source x branch kind x eq x sign; taken branches collide with other sources
  task automatic t_grid;
    logic [15:0] offs [3];
    offs[0] = 16'h0010; offs[1] = 16'hFF00; offs[2] = 16'h7FFF;
    for (int o = 0; o < 3; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 4; k++) begin
          for (int e = 0; e < 2; e++) begin
            for (int n = 0; n < 2; n++) begin
              logic [31:0] rs;
              logic [29:0] pc;
              logic [25:0] jt;
              rs = {n[0], 31'h2468_ACE0 + 31'(o * 64)};
              pc = 30'h1357_9BD0 + 30'(s * 16 + k * 4 + e * 2 + n);
              jt = 26'h0F0_F0F0 ^ 26'(o);
              drive(2'(s), 2'(k), e[0], rs, pc, offs[o], jt);
              check(tag(2'(s), 2'(k)), next_pc_o,
                    model(2'(s), 2'(k), e[0], rs, pc, offs[o], jt));
            end
          end
        end
      end
    end
  endtask

  // R10: same selected source, branch inputs toggled, output must hold
  task automatic t_ignore;
    drive(2'b10, 2'b01, 1'b1, 32'h8765_4320, 30'h100, 16'h0040, 26'h1);
    check("R10 reg eq taken", next_pc_o, 30'h21D9_50C8);
    drive(2'b10, 2'b10, 1'b0, 32'h8765_4320, 30'h100, 16'hC000, 26'h1);
    check("R10 reg ne taken", next_pc_o, 30'h21D9_50C8);
    drive(2'b01, 2'b11, 1'b0, 32'h8000_0000, 30'h100, 16'h0040, 26'h2);
    check("R10 jump ltz taken", next_pc_o, 30'h0000_0002);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_increment();
    t_offsets();
    t_jump();
    t_register();
    t_trap();
    t_grid();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule